// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block keeps reading the status register of a serial flash until the status reaches the state it is waiting for. It does not drive the flash pins itself. It asks a command sequencer to run one status-read command and takes back the bytes that command returned. The request and the response each use a valid/ready handshake.

Each returned status word is trimmed to the configured number of bytes. It is then compared with a match value, but only on the bits that the mask enables. The comparison uses one of two rules: every enabled bit equal (AND), or at least one enabled bit equal (OR). A hit sets a sticky match flag, and that flag can raise an interrupt. After each read the engine waits a programmable number of idle cycles before it issues the next one.

Polling runs in one of two ways. In the first it stops on the first hit. In the second it continues until software aborts it or drops the enable. The engine shows busy while polling and pulses done for one cycle when polling ends.

Request rules. `req_valid` stays high, with nothing else changing, until the sequencer raises `req_ready`. The handshake happens on the clock edge where both are high.

Response rules. `rsp_ready` is high only while the engine waits for a response, so the sequencer may hold `rsp_valid` for as long as it needs. Taking a response stands for the chip-select release that ends the read, and the interval count starts from that point. The configuration inputs must stay constant while `busy` is high.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `busy`, `req_valid`, `rsp_ready`, `done`, `status_match` and `match_irq` are low and `last_status` is zero.
- R2: A `start` pulse while `enable` is high and the engine is idle raises `req_valid` in the next cycle. `req_valid` then stays high until the cycle in which `req_ready` is high.
- R3: `cfg_size` chooses the status length: 0 means 1 byte, 1 means 2 bytes, 2 means 3 bytes and 3 means 4 bytes. Byte 0 is `rsp_data[7:0]` and the bytes count upward from there. Only the chosen bytes are compared. `last_status` takes each accepted response, matched or not, with the bytes above the chosen size cleared to zero.
- R4: When `cfg_or_mode` is 0 (AND rule), a response matches when every bit set in `cfg_mask` within the chosen bytes equals the same bit of `cfg_match`. If no bit is enabled, every response matches.
- R5: When `cfg_or_mode` is 1 (OR rule), a response matches when at least one enabled bit equals its bit of `cfg_match`. If no bit is enabled, no response matches.
- R6: After a response is accepted and polling goes on, `req_valid` stays low for exactly `cfg_interval` cycles (0 to 65535) and then rises. With an interval of 0 it is high in the very next cycle.
- R7: When `cfg_auto_stop` is 1, a matching response ends polling. `busy` is low in the next cycle, `done` is high for exactly that one cycle, and no further request is made.
- R8: When `cfg_auto_stop` is 0, polling continues after a match, and the match flag is still set.
- R9: `abort`, or `enable` going low, while the engine is busy ends polling on that edge, with `busy` falling and a one-cycle `done`. A response offered in the same cycle is thrown away, and `last_status` and the flag keep their values.
- R10: `status_match` is set by a matching response and stays set until a `match_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins. `match_irq` is high exactly when `status_match` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable; dropping it ends polling |
| start | input | 1 | Pulse that begins polling |
| abort | input | 1 | Pulse that ends polling |
| cfg_mask | input | 32 | Bits that take part in the comparison |
| cfg_match | input | 32 | Value to compare against |
| cfg_size | input | 2 | Status length minus one, in bytes |
| cfg_or_mode | input | 1 | 0 selects the AND rule, 1 selects the OR rule |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_auto_stop | input | 1 | Stop polling on the first match |
| irq_en | input | 1 | Interrupt enable |
| match_clr | input | 1 | Clears the match flag |
| req_valid | output | 1 | Status-read request to the sequencer |
| req_ready | input | 1 | Sequencer accepts the request |
| rsp_valid | input | 1 | Sequencer offers status bytes |
| rsp_ready | output | 1 | Engine is waiting for a response |
| rsp_data | input | 32 | Returned status bytes |
| status_match | output | 1 | Sticky match flag |
| match_irq | output | 1 | Match interrupt |
| last_status | output | 32 | Last accepted status word |
| busy | output | 1 | Polling is in progress |
| done | output | 1 | One-cycle pulse when polling ends |

## Verification
The hardest case to reach from the ports is a response and an abort in the same cycle, because the abort must win and the response must leave no trace. A close second is a flag clear that lands on the same edge as a new match. The stimulus reaches both cases with its own handshake sequence. It holds the request until the engine waits, then drives `rsp_valid` together with `abort`, or with `match_clr`, on the same falling edge. Random configurations run alongside these directed cases and cover every status size and both rules. About a third of the random status words are built to match, so both hits and misses occur.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } fps_state_e;
endpackage

// File: rtl/fps_matcher.sv
module fps_matcher #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int SZ_W = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] match_val,
  input  logic [SZ_W-1:0]   size,
  input  logic              or_mode,
  output logic              hit,
  output logic [DATA_W-1:0] kept
);
  logic [DATA_W-1:0] lane_mask;

  // One lane per status byte; a lane is live when its index is within size.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = (b <= int'(size)) ? 8'hFF : 8'h00;
  end

  logic [DATA_W-1:0] eff_mask;
  logic [DATA_W-1:0] same;

  assign eff_mask = mask & lane_mask;
  assign same     = ~(data ^ match_val);
  assign kept     = data & lane_mask;

  always_comb begin
    if (or_mode) hit = |(same & eff_mask);
    else         hit = ((~same) & eff_mask) == '0;
  end
endmodule

// File: rtl/fps_gap_timer.sv
module fps_gap_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IVL_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  logic [IVL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = run && (cnt == IVL_W'(1));
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             abort,
  input  logic             auto_stop,
  input  logic [IVL_W-1:0] interval,
  input  logic             hit,
  input  logic             gap_last,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             req_valid,
  output logic             rsp_ready,
  output logic             rsp_fire,
  output logic             gap_load,
  output logic             gap_run,
  output logic             busy,
  output logic             done
);
  fps_state_e st, st_nx;
  logic stop;

  assign busy      = (st != ST_IDLE);
  assign req_valid = (st == ST_REQ);
  assign rsp_ready = (st == ST_WAIT);
  assign gap_run   = (st == ST_GAP);
  assign stop      = busy && (abort || !enable);
  assign rsp_fire  = rsp_valid && rsp_ready && !stop;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start && enable) st_nx = ST_REQ;
      ST_REQ:  if (req_ready) st_nx = ST_WAIT;
      ST_WAIT: begin
        if (rsp_fire) begin
          if (hit && auto_stop)    st_nx = ST_IDLE;
          else if (interval == '0) st_nx = ST_REQ;
          else                     st_nx = ST_GAP;
        end
      end
      ST_GAP:  if (gap_last) st_nx = ST_REQ;
      default: st_nx = ST_IDLE;
    endcase
    if (stop) st_nx = ST_IDLE;
  end

  assign gap_load = rsp_fire && (st_nx == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= busy && (st_nx == ST_IDLE);
    end
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int DATA_W = 32,
  parameter int IVL_W  = 16,
  localparam int NBYTES = DATA_W / 8,
  localparam int SZ_W   = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [DATA_W-1:0] cfg_match,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              cfg_or_mode,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic              cfg_auto_stop,
  input  logic              irq_en,
  input  logic              match_clr,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              status_match,
  output logic              match_irq,
  output logic [DATA_W-1:0] last_status,
  output logic              busy,
  output logic              done
);
  logic              hit;
  logic [DATA_W-1:0] kept;
  logic              gap_last, gap_load, gap_run, rsp_fire;

  fps_matcher #(.DATA_W(DATA_W)) u_match (
    .data(rsp_data), .mask(cfg_mask), .match_val(cfg_match),
    .size(cfg_size), .or_mode(cfg_or_mode), .hit(hit), .kept(kept)
  );

  fps_gap_timer #(.IVL_W(IVL_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(cfg_interval),
    .run(gap_run), .last(gap_last)
  );

  fps_ctrl #(.IVL_W(IVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .abort(abort),
    .auto_stop(cfg_auto_stop), .interval(cfg_interval), .hit(hit),
    .gap_last(gap_last), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .req_valid(req_valid), .rsp_ready(rsp_ready), .rsp_fire(rsp_fire),
    .gap_load(gap_load), .gap_run(gap_run), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_status  <= '0;
      status_match <= 1'b0;
    end else begin
      if (rsp_fire) last_status <= kept;
      if (rsp_fire && hit) status_match <= 1'b1;
      else if (match_clr)  status_match <= 1'b0;
    end
  end

  assign match_irq = status_match && irq_en;
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic abort,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic busy,
  input logic done,
  input logic status_match
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort && enable |=> req_valid);

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || rsp_ready) |-> busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  flag_from_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_match) |-> $past(rsp_valid && rsp_ready));
endmodule

bind flash_status_poller fps_checker u_fps_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .abort(abort),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .busy(busy), .done(done), .status_match(status_match)
);

// File: tb/test_flash_status_poller.sv
`timescale 1ns/1ps
module test_flash_status_poller;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1, start = 1'b0, abort = 1'b0;
  logic [31:0] cfg_mask = '0, cfg_match = '0;
  logic [1:0]  cfg_size = 2'd3;
  logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1, irq_en = 1'b0, match_clr = 1'b0;
  logic [15:0] cfg_interval = '0;
  logic        req_valid, req_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        status_match, match_irq, busy, done;
  logic [31:0] last_status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_status_poller i_flash_status_poller (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .abort(abort),
    .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_size(cfg_size),
    .cfg_or_mode(cfg_or_mode), .cfg_interval(cfg_interval),
    .cfg_auto_stop(cfg_auto_stop), .irq_en(irq_en), .match_clr(match_clr),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .status_match(status_match),
    .match_irq(match_irq), .last_status(last_status), .busy(busy), .done(done)
  );

  function automatic logic [31:0] lanes(input logic [1:0] sz);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (b <= int'(sz)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic exp_hit(input logic [31:0] d, input logic [31:0] mk,
                                   input logic [31:0] mv, input logic [1:0] sz,
                                   input logic orm);
    logic any_eq = 1'b0;
    logic all_eq = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (mk[i] && lanes(sz)[i]) begin
        if (d[i] == mv[i]) any_eq = 1'b1;
        else               all_eq = 1'b0;
      end
    end
    return orm ? any_eq : all_eq;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic grant();
    for (int i = 0; i < 300 && !req_valid; i++) tick();
    req_ready = 1'b1; tick(); req_ready = 1'b0;
  endtask

  task automatic serve(input logic [31:0] d, input logic clr_too);
    grant();
    rsp_valid = 1'b1; rsp_data = d; match_clr = clr_too;
    tick();
    rsp_valid = 1'b0; match_clr = 1'b0;
  endtask

  task automatic clear_flag();
    match_clr = 1'b1; tick(); match_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    logic h;
    int n;
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 req_valid", req_valid, 0);
    check("R1 rsp_ready", rsp_ready, 0);
    check("R1 done", done, 0);
    check("R1 flag", status_match, 0);
    check("R1 irq", match_irq, 0);
    check("R1 last_status", last_status, 0);

    // R2 request held until ready
    cfg_mask = 32'hFF; cfg_match = 32'h01; cfg_size = 2'd0; cfg_auto_stop = 1'b1;
    go();
    repeat (5) begin
      check("R2 req held", req_valid, 1);
      tick();
    end
    serve(32'h0000_0001, 1'b0);
    check("R7 auto stop busy", busy, 0);
    check("R7 done pulse", done, 1);
    tick();
    check("R7 done one cycle", done, 0);
    check("R7 no more request", req_valid, 0);

    // R3 size: one byte, upper bytes ignored and cleared
    clear_flag();
    cfg_mask = 32'hFFFF_FFFF; cfg_match = 32'h0000_00AB; cfg_size = 2'd0; cfg_or_mode = 1'b0;
    go(); serve(32'hFFFF_FFAB, 1'b0);
    check("R3 upper bytes ignored", status_match, 1);
    check("R3 last_status trimmed", last_status, 32'h0000_00AB);

    // R4/R5 empty mask
    clear_flag();
    cfg_mask = '0; cfg_size = 2'd3; cfg_or_mode = 1'b0;
    go(); serve(32'h1234_5678, 1'b0);
    check("R4 empty mask AND matches", status_match, 1);
    clear_flag();
    cfg_or_mode = 1'b1; cfg_interval = 16'd0;
    go(); serve(32'h1234_5678, 1'b0);
    check("R5 empty mask OR no match", status_match, 0);
    check("R5 still polling", busy, 1);
    abort = 1'b1; tick(); abort = 1'b0;
    check("R9 abort ends", busy, 0);

    // R6/R8 interval and continuous mode
    clear_flag();
    cfg_or_mode = 1'b0; cfg_mask = 32'h0000_0003; cfg_match = 32'h0000_0002;
    cfg_auto_stop = 1'b0; cfg_interval = 16'd3; irq_en = 1'b1;
    go(); serve(32'h0000_0000, 1'b0);
    n = 0;
    while (!req_valid && n < 100) begin n++; tick(); end
    check("R6 gap of 3", n, 3);
    cfg_interval = 16'd0;
    serve(32'h0000_0002, 1'b0);
    check("R8 flag set", status_match, 1);
    check("R10 irq", match_irq, 1);
    check("R8 continues", busy, 1);
    check("R6 zero gap", req_valid, 1);

    // R10 set beats clear in the same cycle
    serve(32'h0000_0002, 1'b1);
    check("R10 set wins", status_match, 1);
    irq_en = 1'b0; tick();
    check("R10 irq masked", match_irq, 0);
    clear_flag();
    check("R10 cleared", status_match, 0);

    // R9 abort with a response in the same cycle
    prev = last_status;
    grant();
    rsp_valid = 1'b1; rsp_data = 32'h0000_0002; abort = 1'b1;
    tick();
    rsp_valid = 1'b0; abort = 1'b0;
    check("R9 abort busy", busy, 0);
    check("R9 abort done", done, 1);
    check("R9 response dropped", last_status, prev);
    check("R9 flag untouched", status_match, 0);

    // R9 enable low during the gap
    cfg_interval = 16'd10;
    go(); serve(32'h0000_0001, 1'b0);
    tick();
    enable = 1'b0; tick(); enable = 1'b1;
    check("R9 disable busy", busy, 0);
    check("R9 disable done", done, 1);

    // Random single polls with automatic stop
    cfg_auto_stop = 1'b1; cfg_interval = 16'd0;
    for (int it = 0; it < 60; it++) begin
      clear_flag();
      cfg_mask = $urandom; cfg_match = $urandom; cfg_size = 2'($urandom % 4);
      cfg_or_mode = 1'($urandom % 2); irq_en = 1'($urandom % 2);
      if ($urandom % 3 == 0) d = cfg_match ^ ($urandom & ~cfg_mask);
      else d = $urandom;
      h = exp_hit(d, cfg_mask, cfg_match, cfg_size, cfg_or_mode);
      go(); serve(d, 1'b0);
      check(cfg_or_mode ? "R5 random flag" : "R4 random flag", status_match, h);
      check("R3 random last_status", last_status, d & lanes(cfg_size));
      check("R10 random irq", match_irq, h & irq_en);
      check("R7 random busy", busy, !h);
      check("R7 random done", done, h);
      if (!h) begin
        abort = 1'b1; tick(); abort = 1'b0;
        check("R9 random abort", done, 1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule